// File: doc/BRIEF.md
# Conversion-Start and Readout-Burst Timer

This block drives a fast successive-approximation converter whose result leaves the chip on a serial clock. It makes two periodic waveforms from one reference clock. The first is a conversion-start pulse, which is high for a programmed number of cycles at the start of every sample period. The second is a gate that opens a burst of readout clocks. The gate has the same period as the conversion pulse and starts a programmed number of cycles after the conversion edge. It stays open for one reference cycle per result bit, times a fixed cycles-per-bit factor.

Software supplies the period, the conversion-high time, the burst offset and the result resolution, all counted in reference-clock cycles. The block first limits the period to the range the converter allows, and a narrow-bandwidth input raises the lower limit of that range. One enable input starts and stops both waveforms together. A new setting waits for the next period boundary before it applies, and a setting that cannot be timed is refused. A small sequential divider reports the sample rate that results, in kHz and rounded to the nearest value.

Top module: `conv_burst_timer`

## Requirements
- R1: After reset, conv_out, burst_gate, running, cfg_err and rate_valid are all 0.
- R2: The applied period is cfg_period clamped to the range MIN_PERIOD (default 13) to MAX_PERIOD (default 1250) cycles. The distance between consecutive conv_out rising edges equals this clamped value.
- R3: Once enable is seen high by a clock edge, conv_out is high in the next cycle. In every period conv_out stays high for exactly cfg_conv_high cycles, starting at phase 0.
- R4: When the offset is nonzero, burst_gate rises offset cycles after each conv_out rising edge, the first period included. It stays high for cfg_bits × CYC_PER_BIT cycles (default factor 1).
- R5: An offset of 0 means a delay of one full period. The first burst opens at the start of the second period, and after that each burst opens at the same time as a conv_out rising edge.
- R6: A change to the configuration inputs while running takes effect only at the next period boundary. The period that is under way finishes with its old length.
- R7: A configuration is rejected when the offset is at least the clamped period, when the conversion-high time is 0 or at least the period, or when the bit count is 0. At a boundary, a rejected setting leaves the old one in force and sets cfg_err. The next accepted setting clears cfg_err.
- R8: If enable rises while the configuration is invalid, neither waveform starts, running stays 0 and cfg_err is set.
- R9: When enable is low at a clock edge while the block is running, conv_out, burst_gate and running are all 0 in the following cycle.
- R10: While narrow_bw is 1, the lower limit of the period is NARROW_MIN_PERIOD (default 63 cycles) and not MIN_PERIOD.
- R11: Each time a new period is loaded, rate_valid goes low. Within QW+1 cycles, rate_khz becomes (REF_KHZ + P/2) / P, rounded down, where P is the applied period, and rate_valid returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs both waveforms while high |
| narrow_bw | input | 1 | Raises the minimum period to the narrow-bandwidth limit |
| cfg_period | input | PER_W (12) | Requested sample period in cycles |
| cfg_conv_high | input | PER_W (12) | Conversion pulse high time in cycles |
| cfg_offset | input | PER_W (12) | Burst start delay after the conversion edge in cycles; 0 means one full period |
| cfg_bits | input | BITS_W (5) | Result resolution in bits |
| conv_out | output | 1 | Conversion-start pulse |
| burst_gate | output | 1 | Readout clock gate window |
| running | output | 1 | Waveforms active |
| cfg_err | output | 1 | Last configuration load was rejected |
| rate_khz | output | QW (17) | Achieved sample rate in kHz |
| rate_valid | output | 1 | rate_khz holds the result for the current period |

## Verification
The hardest case to create from the ports is a configuration that changes in the middle of a running period. This covers both a legal change that must wait for the boundary and an illegal offset that must be refused without disturbing the waveform that is under way. The stimulus starts the timer and waits for a conversion edge so that the phase is known. It then changes the period or offset a few cycles into that period and measures the next two edge-to-edge gaps, the error flag and the burst delay. The one-full-period meaning of a zero offset is checked in the same way, from the delay between the first conversion edge and the first burst.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    // Widths of the cycle counters and the resolution field.
    localparam int unsigned PER_W  = 12;
    localparam int unsigned BITS_W = 5;

    typedef logic [PER_W-1:0]  cyc_t;
    typedef logic [BITS_W-1:0] bits_t;

    // One complete waveform setting, in reference-clock cycles.
    typedef struct packed {
        cyc_t period;
        cyc_t conv_high;
        cyc_t offset;
        cyc_t burst_len;
    } wave_cfg_t;

    function automatic cyc_t clamp_period(input cyc_t req, input cyc_t lo, input cyc_t hi);
        cyc_t r;
        if (req < lo)      r = lo;
        else if (req > hi) r = hi;
        else               r = req;
        return r;
    endfunction

    function automatic logic cfg_timeable(input wave_cfg_t c);
        return (c.conv_high != '0) && (c.conv_high < c.period) &&
               (c.offset < c.period) && (c.burst_len != '0);
    endfunction

endpackage

// File: rtl/cbt_cfg_stage.sv
module cbt_cfg_stage
    import cbt_pkg::*;
#(
    parameter int unsigned MIN_PERIOD        = 13,
    parameter int unsigned NARROW_MIN_PERIOD = 63,
    parameter int unsigned MAX_PERIOD        = 1250,
    parameter int unsigned CYC_PER_BIT       = 1
) (
    input  logic      narrow_bw,
    input  cyc_t      req_period,
    input  cyc_t      req_conv_high,
    input  cyc_t      req_offset,
    input  bits_t     req_bits,
    output wave_cfg_t staged,
    output logic      staged_ok
);
    localparam cyc_t LO_WIDE   = cyc_t'(MIN_PERIOD);
    localparam cyc_t LO_NARROW = cyc_t'(NARROW_MIN_PERIOD);
    localparam cyc_t HI_LIMIT  = cyc_t'(MAX_PERIOD);

    cyc_t lo_sel;

    always_comb begin
        lo_sel            = narrow_bw ? LO_NARROW : LO_WIDE;
        staged.period     = clamp_period(req_period, lo_sel, HI_LIMIT);
        staged.conv_high  = req_conv_high;
        staged.offset     = req_offset;
        staged.burst_len  = cyc_t'(32'(req_bits) * CYC_PER_BIT);
        staged_ok         = cfg_timeable(staged);
    end
endmodule

// File: rtl/cbt_phase_gen.sv
module cbt_phase_gen
    import cbt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  wave_cfg_t staged,
    input  logic      staged_ok,
    output logic      running,
    output cyc_t      phase,
    output wave_cfg_t act,
    output logic      conv_out,
    output logic      burst_start,
    output logic      cfg_err,
    output logic      period_load
);
    logic first_q;
    logic at_last;

    assign at_last     = (phase == act.period - 1'b1);
    assign conv_out    = running && (phase < act.conv_high);
    // A zero offset is one full period: the first period has no burst start.
    assign burst_start = running && (phase == act.offset) &&
                         !(first_q && (act.offset == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            running     <= 1'b0;
            phase       <= '0;
            act         <= '0;
            first_q     <= 1'b0;
            cfg_err     <= 1'b0;
            period_load <= 1'b0;
        end else begin
            period_load <= 1'b0;
            if (!running) begin
                phase <= '0;
                if (enable) begin
                    if (staged_ok) begin
                        running     <= 1'b1;
                        act         <= staged;
                        first_q     <= 1'b1;
                        cfg_err     <= 1'b0;
                        period_load <= 1'b1;
                    end else begin
                        cfg_err <= 1'b1;
                    end
                end
            end else if (!enable) begin
                running <= 1'b0;
                phase   <= '0;
            end else if (at_last) begin
                phase   <= '0;
                first_q <= 1'b0;
                if (staged_ok) begin
                    act         <= staged;
                    cfg_err     <= 1'b0;
                    period_load <= (staged.period != act.period);
                end else begin
                    cfg_err <= 1'b1;
                end
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cbt_burst_gen.sv
module cbt_burst_gen
    import cbt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic running,
    input  logic start,
    input  cyc_t len,
    output logic burst_gate
);
    cyc_t left_q;

    assign burst_gate = running && (start || (left_q != '0));

    always_ff @(posedge clk) begin
        if (rst || !running) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= len - 1'b1;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/cbt_rate_div.sv
module cbt_rate_div
    import cbt_pkg::*;
#(
    parameter int unsigned REF_KHZ = 125000,
    parameter int unsigned QW      = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  cyc_t          divisor,
    output logic [QW-1:0] quot,
    output logic          valid
);
    localparam int unsigned CW = $clog2(QW + 1);

    logic [QW-1:0]  dvd_q;
    logic [QW-1:0]  q_q;
    logic [PER_W:0] rem_q;
    logic [CW-1:0]  cnt_q;
    logic           busy_q;
    logic [PER_W:0] trial;
    logic [PER_W:0] rem_next;
    logic           fits;

    always_comb begin
        trial    = {rem_q[PER_W-1:0], dvd_q[QW-1]};
        fits     = (trial >= {1'b0, divisor});
        rem_next = fits ? (trial - {1'b0, divisor}) : trial;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd_q  <= '0;
            q_q    <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            quot   <= '0;
            valid  <= 1'b0;
        end else if (start) begin
            // Adding half the divisor turns the floor into round-to-nearest.
            dvd_q  <= QW'(REF_KHZ) + QW'(divisor >> 1);
            q_q    <= '0;
            rem_q  <= '0;
            cnt_q  <= CW'(QW);
            busy_q <= 1'b1;
            valid  <= 1'b0;
        end else if (busy_q) begin
            dvd_q <= dvd_q << 1;
            q_q   <= {q_q[QW-2:0], fits};
            rem_q <= rem_next;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
                busy_q <= 1'b0;
                valid  <= 1'b1;
                quot   <= {q_q[QW-2:0], fits};
            end
        end
    end
endmodule

// File: rtl/conv_burst_timer.sv
module conv_burst_timer
    import cbt_pkg::*;
#(
    parameter int unsigned MIN_PERIOD        = 13,
    parameter int unsigned NARROW_MIN_PERIOD = 63,
    parameter int unsigned MAX_PERIOD        = 1250,
    parameter int unsigned CYC_PER_BIT       = 1,
    parameter int unsigned REF_KHZ           = 125000,
    localparam int unsigned QW               = $clog2(REF_KHZ + MAX_PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              narrow_bw,
    input  logic [PER_W-1:0]  cfg_period,
    input  logic [PER_W-1:0]  cfg_conv_high,
    input  logic [PER_W-1:0]  cfg_offset,
    input  logic [BITS_W-1:0] cfg_bits,
    output logic              conv_out,
    output logic              burst_gate,
    output logic              running,
    output logic              cfg_err,
    output logic [QW-1:0]     rate_khz,
    output logic              rate_valid
);
    wave_cfg_t staged;
    logic      staged_ok;
    wave_cfg_t cur_cfg;
    cyc_t      cur_phase;
    logic      burst_start;
    logic      period_load;

    cbt_cfg_stage #(
        .MIN_PERIOD       (MIN_PERIOD),
        .NARROW_MIN_PERIOD(NARROW_MIN_PERIOD),
        .MAX_PERIOD       (MAX_PERIOD),
        .CYC_PER_BIT      (CYC_PER_BIT)
    ) u_stage (
        .narrow_bw    (narrow_bw),
        .req_period   (cfg_period),
        .req_conv_high(cfg_conv_high),
        .req_offset   (cfg_offset),
        .req_bits     (cfg_bits),
        .staged       (staged),
        .staged_ok    (staged_ok)
    );

    cbt_phase_gen u_phase (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .staged     (staged),
        .staged_ok  (staged_ok),
        .running    (running),
        .phase      (cur_phase),
        .act        (cur_cfg),
        .conv_out   (conv_out),
        .burst_start(burst_start),
        .cfg_err    (cfg_err),
        .period_load(period_load)
    );

    cbt_burst_gen u_burst (
        .clk       (clk),
        .rst       (rst),
        .running   (running),
        .start     (burst_start),
        .len       (cur_cfg.burst_len),
        .burst_gate(burst_gate)
    );

    cbt_rate_div #(
        .REF_KHZ(REF_KHZ),
        .QW     (QW)
    ) u_rate (
        .clk    (clk),
        .rst    (rst),
        .start  (period_load),
        .divisor(cur_cfg.period),
        .quot   (rate_khz),
        .valid  (rate_valid)
    );
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker
    import cbt_pkg::*;
#(
    parameter int unsigned MIN_PERIOD = 13,
    parameter int unsigned MAX_PERIOD = 1250
) (
    input logic      clk,
    input logic      rst,
    input logic      enable,
    input logic      running,
    input logic      conv_out,
    input logic      burst_gate,
    input cyc_t      phase,
    input wave_cfg_t act
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !running |-> (!conv_out && !burst_gate)); // R9

    AST_STOP_NEXT: assert property (@(posedge clk) disable iff (rst)
        (running && !enable) |=> !running); // R9

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        running |-> (phase < act.period)); // R3

    AST_CONV_AT_PHASE0: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_out) |-> (phase == '0)); // R3

    AST_OFFSET_LEGAL: assert property (@(posedge clk) disable iff (rst)
        running |-> (act.offset < act.period)); // R7

    AST_PERIOD_BOUNDS: assert property (@(posedge clk) disable iff (rst)
        running |-> ((act.period >= cyc_t'(MIN_PERIOD)) && (act.period <= cyc_t'(MAX_PERIOD)))); // R2

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (running && enable && (phase != act.period - 1'b1)) |=> $stable(act)); // R6
endmodule

bind conv_burst_timer cbt_checker #(
    .MIN_PERIOD(MIN_PERIOD),
    .MAX_PERIOD(MAX_PERIOD)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .running   (running),
    .conv_out  (conv_out),
    .burst_gate(burst_gate),
    .phase     (cur_phase),
    .act       (cur_cfg)
);

// File: tb/tb_conv_burst_timer.sv
module tb_conv_burst_timer;
    import cbt_pkg::*;

    localparam int REF = 125000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              enable = 1'b0;
    logic              narrow_bw = 1'b0;
    logic [PER_W-1:0]  cfg_period = '0;
    logic [PER_W-1:0]  cfg_conv_high = '0;
    logic [PER_W-1:0]  cfg_offset = '0;
    logic [BITS_W-1:0] cfg_bits = '0;
    logic              conv_out, burst_gate, running, cfg_err, rate_valid;
    logic [16:0]       rate_khz;

    conv_burst_timer dut (
        .clk(clk), .rst(rst), .enable(enable), .narrow_bw(narrow_bw),
        .cfg_period(cfg_period), .cfg_conv_high(cfg_conv_high),
        .cfg_offset(cfg_offset), .cfg_bits(cfg_bits),
        .conv_out(conv_out), .burst_gate(burst_gate), .running(running),
        .cfg_err(cfg_err), .rate_khz(rate_khz), .rate_valid(rate_valid)
    );

    always #4 clk = ~clk;

    typedef struct {
        int    gap;
        int    hi;
        int    dly;
        int    len;
        string per_tag;
        string bst_tag;
    } rec_t;

    rec_t exp_q[$];
    int checks = 0;
    int errs = 0;
    bit finished = 1'b0;

    int cyc = 0;
    int rises = 0;
    int rise_total = 0;
    int last_rise = 0;
    int gap = 0;
    int hi_w = 0;
    int dly = 0;
    int b_rise = 0;
    int first_conv = -1;
    int first_burst = -1;
    bit prev_conv = 1'b0;
    bit prev_burst = 1'b0;

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: measures waveforms and pops expected records at each burst end.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            if (!running) rises = 0;
            if (conv_out && !prev_conv) begin
                if (rises > 0) gap = cyc - last_rise;
                last_rise = cyc;
                rises++;
                rise_total++;
                if (first_conv < 0) first_conv = cyc;
            end
            if (!conv_out && prev_conv) hi_w = cyc - last_rise;
            if (burst_gate && !prev_burst) begin
                b_rise = cyc;
                dly = cyc - last_rise;
                if (first_burst < 0) first_burst = cyc;
            end
            if (!burst_gate && prev_burst && running && rises >= 2 && exp_q.size() > 0) begin
                rec_t e;
                e = exp_q.pop_front();
                check_eq(e.per_tag, gap, e.gap);
                check_eq("R3", hi_w, e.hi);
                check_eq(e.bst_tag, dly, e.dly);
                check_eq(e.bst_tag, cyc - b_rise, e.len);
            end
            prev_conv = conv_out;
            prev_burst = burst_gate;
        end
    end

    task automatic set_cfg(input int per, input int hi, input int off, input int bits, input bit nb);
        cfg_period    = PER_W'(per);
        cfg_conv_high = PER_W'(hi);
        cfg_offset    = PER_W'(off);
        cfg_bits      = BITS_W'(bits);
        narrow_bw     = nb;
    endtask

    task automatic run_case(input int per, input int hi, input int off, input int bits,
                            input bit nb, input int exp_per, input int n, input string per_tag);
        int en_cyc;
        int t;
        string btag;
        btag = (off == 0) ? "R5" : "R4";
        @(negedge clk);
        enable = 1'b0;
        set_cfg(per, hi, off, bits, nb);
        @(negedge clk);
        first_conv = -1;
        first_burst = -1;
        en_cyc = cyc;
        enable = 1'b1;
        for (int i = 0; i < n; i++) begin
            rec_t r;
            r.gap = exp_per; r.hi = hi; r.dly = off; r.len = bits;
            r.per_tag = per_tag; r.bst_tag = btag;
            exp_q.push_back(r);
        end
        t = 0;
        while (exp_q.size() != 0 && t < (n + 3) * exp_per + 60) begin
            @(negedge clk);
            t++;
        end
        check_eq(per_tag, exp_q.size(), 0);
        exp_q.delete();
        check_eq("R3", first_conv - en_cyc, 1);
        check_eq(btag, first_burst - first_conv, (off == 0) ? exp_per : off);
        check_eq("R11", int'(rate_valid), 1);
        check_eq("R11", int'(rate_khz), (REF + exp_per / 2) / exp_per);
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_rise();
        int r;
        int t;
        r = rise_total;
        t = 0;
        while (rise_total == r && t < 3000) begin
            @(negedge clk);
            t++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_eq("R1", int'(conv_out), 0);
        check_eq("R1", int'(burst_gate), 0);
        check_eq("R1", int'(running), 0);
        check_eq("R1", int'(cfg_err), 0);
        check_eq("R1", int'(rate_valid), 0);

        // Main patterns: zero offset, spilled burst, short period, clamps, narrow mode
        run_case(25, 10, 0, 18, 1'b0, 25, 3, "R3");
        run_case(21, 5, 19, 16, 1'b0, 21, 3, "R4");
        run_case(13, 5, 3, 8, 1'b0, 13, 3, "R4");
        run_case(5, 4, 6, 4, 1'b0, 13, 3, "R2");
        run_case(20, 10, 30, 18, 1'b1, 63, 3, "R10");
        run_case(3000, 5, 100, 16, 1'b0, 1250, 2, "R2");

        // R6: mid-period change waits for the boundary
        @(negedge clk);
        set_cfg(25, 10, 0, 18, 1'b0);
        enable = 1'b1;
        wait_rise();
        wait_rise();
        repeat (3) @(negedge clk);
        cfg_period = PER_W'(40);
        wait_rise();
        check_eq("R6", gap, 25);
        wait_rise();
        check_eq("R6", gap, 40);

        // R7: illegal offset refused, old setting kept, flag raised then cleared
        repeat (4) @(negedge clk);
        cfg_offset = PER_W'(45);
        wait_rise();
        wait_rise();
        check_eq("R7", gap, 40);
        check_eq("R7", int'(cfg_err), 1);
        repeat (4) @(negedge clk);
        cfg_offset = PER_W'(2);
        wait_rise();
        repeat (5) @(negedge clk);
        check_eq("R7", int'(cfg_err), 0);
        check_eq("R7", dly, 2);

        // R9: stop while both waveforms are high
        cfg_offset = '0;
        wait_rise();
        wait_rise();
        check_eq("R9", int'(conv_out && burst_gate), 1);
        enable = 1'b0;
        @(negedge clk);
        check_eq("R9", int'(conv_out), 0);
        check_eq("R9", int'(burst_gate), 0);
        check_eq("R9", int'(running), 0);

        // R8: start with an untimeable setting
        begin
            int r0;
            set_cfg(25, 10, 30, 18, 1'b0);
            @(negedge clk);
            r0 = rise_total;
            enable = 1'b1;
            repeat (60) @(negedge clk);
            check_eq("R8", rise_total - r0, 0);
            check_eq("R8", int'(running), 0);
            check_eq("R8", int'(cfg_err), 1);
            check_eq("R8", int'(burst_gate), 0);
            enable = 1'b0;
        end

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule